// File: doc/BRIEF.md
# FSK Caller-ID Bit Sequencer

This block produces the serial bit stream for an on-hook caller-ID burst aimed at one of eight voice channels. Software programs a seizure length, a mark length and a data length, loads up to 64 message bytes into an internal buffer, and then sets a start bit. The block sends three phases in order. The seizure phase is a run of alternating bits. The mark phase is a run of ones. The data phase sends each message byte framed with a start bit and a stop bit. The stream advances by one bit on each pulse of a bit-rate clock enable. A downstream modulator turns the stream into tones and is not part of this block.

When the message ends, the start bit clears itself. The output then either goes quiet or, if the hold option is set, keeps sending ones until software arms a new burst. A mode bit selects the UK convention, which has no seizure phase. A master enable stops the block at any time. The output carries the bit value, a valid flag (low means muted) and the 3-bit code of the target channel.

Top module: `fsk_cid_sequencer`

## Requirements
- R1: Register access uses a command byte on `reg_cmd`. Bit 7 = 0 writes `reg_wdata`, and bit 7 = 1 reads. The low 7 bits hold the address: 0x35 seizure length, 0x36 data length in bytes, 0x37 mark length, 0x38 control. Read data appears on `reg_rdata` after the clock edge that samples the read request and holds until the next read. Control bit layout: bit0 start, bit1 hold-after-send, bit2 UK mode, bits5:3 channel code, bit6 reads 0, bit7 enable.
- R2: After reset, every register reads 0, `tx_valid` is 0, `tx_bit` is 1 and `tx_chan` is 0.
- R3: A control write with start = 1 and enable = 1 begins the burst on the following cycle. Phases run in the order seizure, mark, data. Each `bit_en` pulse moves to the next bit, and `tx_bit` and `tx_valid` hold their values between pulses.
- R4: The seizure phase sends the programmed number of alternating bits, starting with 0. In UK mode (control bit2 = 1) the seizure phase is skipped.
- R5: The mark phase sends the programmed number of ones. A mark length of 0 sends no mark bits.
- R6: Each data byte is sent as a 0 start bit, then eight data bits LSB first, then a 1 stop bit. Bytes come from buffer addresses 0 upward. A data length above 64 is treated as 64.
- R7: The start bit reads 1 while a burst runs and clears after the last stop bit. With hold-after-send = 0, the output is then muted (`tx_valid` = 0, `tx_bit` = 1).
- R8: With hold-after-send = 1, valid ones follow the message indefinitely. A start written while hold-after-send is still 1 does not change the output. A control write with hold-after-send = 0 and start = 1 begins a new burst.
- R9: If the seizure, mark and data lengths are all 0 when start is written, the start bit clears one cycle later and nothing is sent.
- R10: When enable is cleared, the output is muted from the next cycle, any burst in progress is abandoned, and the start bit is cleared.
- R11: `tx_chan` carries the control channel code. Code n selects channel n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit-rate clock enable |
| reg_req | input | 1 | Register access strobe |
| reg_cmd | input | 8 | Command byte: bit 7 selects read, bits 6:0 hold the address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| buf_wr | input | 1 | Message buffer write strobe |
| buf_addr | input | 6 | Message buffer write address |
| buf_wdata | input | 8 | Message buffer write byte |
| tx_bit | output | 1 | Serial bit value |
| tx_valid | output | 1 | Bit valid; low means the output is muted |
| tx_chan | output | 3 | Target channel code |

## Verification
The stream is tried with bursts of several shapes. A full North American burst with a sparse bit enable shows phase order, seizure polarity and that bits hold between pulses. A UK burst with a programmed seizure length checks that the phase is really skipped. A zero mark length checks that seizure leads straight into data. A 100-byte request checks the clamp at 64 bytes. Further runs cover the hold-after-send path, the all-zero-lengths case and a disable in mid-burst, which separate the three ways a burst can end.

// File: rtl/fsk_cid_pkg.sv
package fsk_cid_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SEIZE = 3'd1,
        ST_MARK  = 3'd2,
        ST_DATA  = 3'd3,
        ST_HOLD  = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic       enable;
        logic [2:0] chan;
        logic       uk_mode;
        logic       hold_ones;
        logic       start;
    } ctrl_t;

endpackage

// File: rtl/fsk_cid_regs.sv
module fsk_cid_regs
    import fsk_cid_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [7:0]       cmd_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             start_clr_i,
    output logic [REG_W-1:0] rdata_o,
    output logic [REG_W-1:0] seiz_len_o,
    output logic [REG_W-1:0] data_len_o,
    output logic [REG_W-1:0] mark_len_o,
    output ctrl_t            ctrl_o
);
    localparam logic [6:0] A_SEIZE = 7'h35;
    localparam logic [6:0] A_DLEN  = 7'h36;
    localparam logic [6:0] A_MARK  = 7'h37;
    localparam logic [6:0] A_CTRL  = 7'h38;

    typedef struct packed {
        logic [REG_W-1:0] seiz;
        logic [REG_W-1:0] dlen;
        logic [REG_W-1:0] mark;
        ctrl_t            ctrl;
        logic [REG_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr, rd;

    always_comb begin
        r_d = r_q;
        wr  = req_i && !cmd_i[7];
        rd  = req_i &&  cmd_i[7];
        if (wr && cmd_i[6:0] == A_CTRL) begin
            r_d.ctrl.start     = wdata_i[0];
            r_d.ctrl.hold_ones = wdata_i[1];
            r_d.ctrl.uk_mode   = wdata_i[2];
            r_d.ctrl.chan      = wdata_i[5:3];
            r_d.ctrl.enable    = wdata_i[7];
        end else if (start_clr_i || !r_q.ctrl.enable) begin
            r_d.ctrl.start = 1'b0;
        end
        if (wr) begin
            case (cmd_i[6:0])
                A_SEIZE: r_d.seiz = wdata_i;
                A_DLEN:  r_d.dlen = wdata_i;
                A_MARK:  r_d.mark = wdata_i;
                default: ;
            endcase
        end
        if (rd) begin
            case (cmd_i[6:0])
                A_SEIZE: r_d.rdata = r_q.seiz;
                A_DLEN:  r_d.rdata = r_q.dlen;
                A_MARK:  r_d.rdata = r_q.mark;
                A_CTRL:  r_d.rdata = REG_W'({r_q.ctrl.enable, 1'b0, r_q.ctrl.chan,
                                             r_q.ctrl.uk_mode, r_q.ctrl.hold_ones,
                                             r_q.ctrl.start});
                default: r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata_o    = r_q.rdata;
    assign seiz_len_o = r_q.seiz;
    assign data_len_o = r_q.dlen;
    assign mark_len_o = r_q.mark;
    assign ctrl_o     = r_q.ctrl;

    // R1
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> $stable(rdata_o));

endmodule

// File: rtl/fsk_cid_msgbuf.sv
module fsk_cid_msgbuf #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [W-1:0]  rdata_o
);
    // Plain storage: contents are undefined until software loads them.
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/fsk_cid_seq.sv
module fsk_cid_seq
    import fsk_cid_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int LEN_W  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en_i,
    input  logic             enable_i,
    input  logic             start_i,
    input  logic             hold_ones_i,
    input  logic             uk_i,
    input  logic [LEN_W-1:0] seiz_len_i,
    input  logic [LEN_W-1:0] mark_len_i,
    input  logic [LEN_W-1:0] data_len_i,
    input  logic [7:0]       byte_i,
    output logic [IDX_W-1:0] byte_addr_o,
    output logic             start_clr_o,
    output logic             bit_o,
    output logic             valid_o
);
    localparam logic [LEN_W-1:0] LAST_FRAME_BIT = LEN_W'(9);
    localparam logic [LEN_W-1:0] MAX_BYTES      = LEN_W'(DEPTH);

    typedef struct packed {
        seq_state_e       state;
        logic [LEN_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t             s_d, s_q;
    logic [LEN_W-1:0] dlen_eff;
    logic             all_zero, launch_ok, finish;
    seq_state_e       nxt;
    logic [3:0]       bpos;

    function automatic seq_state_e pick(input logic try_seize, input logic try_mark,
                                        input logic try_data);
        if (try_seize)     return ST_SEIZE;
        else if (try_mark) return ST_MARK;
        else if (try_data) return ST_DATA;
        else               return ST_IDLE;
    endfunction

    always_comb begin
        dlen_eff  = (data_len_i > MAX_BYTES) ? MAX_BYTES : data_len_i;
        all_zero  = (seiz_len_i == '0) && (mark_len_i == '0) && (data_len_i == '0);
        launch_ok = start_i && (s_q.state == ST_IDLE || (s_q.state == ST_HOLD && !hold_ones_i));
        s_d         = s_q;
        start_clr_o = 1'b0;
        finish      = 1'b0;
        nxt         = ST_IDLE;
        if (!enable_i) begin
            s_d = '0;
        end else begin
            case (s_q.state)
                ST_IDLE, ST_HOLD: begin
                    if (launch_ok) begin
                        s_d.cnt = '0;
                        s_d.idx = '0;
                        if (all_zero) begin
                            start_clr_o = 1'b1;
                            s_d.state   = ST_IDLE;
                        end else begin
                            nxt = pick(seiz_len_i != '0 && !uk_i, mark_len_i != '0, dlen_eff != '0);
                            if (nxt == ST_IDLE) finish = 1'b1;
                            else                s_d.state = nxt;
                        end
                    end
                end
                ST_SEIZE, ST_MARK: begin
                    if (bit_en_i) begin
                        if (s_q.cnt == ((s_q.state == ST_SEIZE ? seiz_len_i : mark_len_i) - LEN_W'(1))) begin
                            s_d.cnt = '0;
                            nxt = pick(1'b0, s_q.state == ST_SEIZE && mark_len_i != '0, dlen_eff != '0);
                            if (nxt == ST_IDLE) finish = 1'b1;
                            else                s_d.state = nxt;
                        end else begin
                            s_d.cnt = s_q.cnt + LEN_W'(1);
                        end
                    end
                end
                ST_DATA: begin
                    if (bit_en_i) begin
                        if (s_q.cnt == LAST_FRAME_BIT) begin
                            s_d.cnt = '0;
                            if (LEN_W'(s_q.idx) == dlen_eff - LEN_W'(1)) finish = 1'b1;
                            else s_d.idx = s_q.idx + IDX_W'(1);
                        end else begin
                            s_d.cnt = s_q.cnt + LEN_W'(1);
                        end
                    end
                end
                default: s_d = '0;
            endcase
            if (finish) begin
                start_clr_o = 1'b1;
                s_d.state   = hold_ones_i ? ST_HOLD : ST_IDLE;
                s_d.cnt     = '0;
                s_d.idx     = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign byte_addr_o = s_q.idx;
    assign bpos        = s_q.cnt[3:0] - 4'd1;

    always_comb begin
        valid_o = 1'b1;
        bit_o   = 1'b1;
        case (s_q.state)
            ST_SEIZE: bit_o = s_q.cnt[0];
            ST_DATA: begin
                if (s_q.cnt == '0)                 bit_o = 1'b0;
                else if (s_q.cnt != LAST_FRAME_BIT) bit_o = byte_i[bpos[2:0]];
            end
            ST_MARK, ST_HOLD: bit_o = 1'b1;
            default: valid_o = 1'b0;
        endcase
    end

    // R10
    disabled_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !valid_o);

    // R3
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state inside {ST_SEIZE, ST_MARK, ST_DATA}) && !bit_en_i && enable_i
        |=> $stable(bit_o) && valid_o);

    // R9
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.state == ST_IDLE && enable_i && start_i && all_zero |=> !valid_o);

    // R8
    hold_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.state == ST_HOLD && enable_i && !start_i |=> valid_o && bit_o);

    // R7
    start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_clr_o && !hold_ones_i && enable_i |=> !valid_o);

endmodule

// File: rtl/fsk_cid_sequencer.sv
module fsk_cid_sequencer
    import fsk_cid_pkg::*;
#(
    parameter int BUF_DEPTH = 64,
    parameter int LEN_W     = 8,
    localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             reg_req,
    input  logic [7:0]       reg_cmd,
    input  logic [LEN_W-1:0] reg_wdata,
    output logic [LEN_W-1:0] reg_rdata,
    input  logic             buf_wr,
    input  logic [IDX_W-1:0] buf_addr,
    input  logic [7:0]       buf_wdata,
    output logic             tx_bit,
    output logic             tx_valid,
    output logic [2:0]       tx_chan
);
    ctrl_t            ctrl;
    logic [LEN_W-1:0] seiz_len, data_len, mark_len;
    logic             start_clr;
    logic [IDX_W-1:0] rd_addr;
    logic [7:0]       cur_byte;

    fsk_cid_regs #(.REG_W(LEN_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (reg_req),
        .cmd_i       (reg_cmd),
        .wdata_i     (reg_wdata),
        .start_clr_i (start_clr),
        .rdata_o     (reg_rdata),
        .seiz_len_o  (seiz_len),
        .data_len_o  (data_len),
        .mark_len_o  (mark_len),
        .ctrl_o      (ctrl)
    );

    fsk_cid_msgbuf #(.DEPTH(BUF_DEPTH), .W(8)) u_buf (
        .clk     (clk),
        .wr_i    (buf_wr),
        .waddr_i (buf_addr),
        .wdata_i (buf_wdata),
        .raddr_i (rd_addr),
        .rdata_o (cur_byte)
    );

    fsk_cid_seq #(.DEPTH(BUF_DEPTH), .LEN_W(LEN_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en_i    (bit_en),
        .enable_i    (ctrl.enable),
        .start_i     (ctrl.start),
        .hold_ones_i (ctrl.hold_ones),
        .uk_i        (ctrl.uk_mode),
        .seiz_len_i  (seiz_len),
        .mark_len_i  (mark_len),
        .data_len_i  (data_len),
        .byte_i      (cur_byte),
        .byte_addr_o (rd_addr),
        .start_clr_o (start_clr),
        .bit_o       (tx_bit),
        .valid_o     (tx_valid)
    );

    assign tx_chan = ctrl.chan;

endmodule

// File: tb/fsk_cid_sequencer_tb.sv
module fsk_cid_sequencer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       reg_req = 1'b0;
    logic [7:0] reg_cmd = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       buf_wr = 1'b0;
    logic [5:0] buf_addr = '0;
    logic [7:0] buf_wdata = '0;
    logic       tx_bit, tx_valid;
    logic [2:0] tx_chan;

    always #2 clk = ~clk;

    fsk_cid_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .reg_req(reg_req),
        .reg_cmd(reg_cmd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .buf_wr(buf_wr), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .tx_bit(tx_bit), .tx_valid(tx_valid), .tx_chan(tx_chan)
    );

    int total = 0;
    int bad = 0;
    int vcount = 0;
    string tag = "R2 reset";

    // reference model: 0 idle, 1 pending launch, 2 running, 3 holding ones
    int       m_state = 0;
    bit       m_from_hold = 0;
    bit       q[$];
    int       m_seiz = 0, m_mark = 0, m_dlen = 0;
    bit       m_en = 0, m_hold = 0, m_uk = 0;
    bit [2:0] m_chan = 0;
    bit [7:0] m_mem [64];

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic build();
        int nb;
        q.delete();
        if (!m_uk) for (int i = 0; i < m_seiz; i++) q.push_back(bit'(i % 2));
        for (int i = 0; i < m_mark; i++) q.push_back(1'b1);
        nb = (m_dlen > 64) ? 64 : m_dlen;
        for (int b = 0; b < nb; b++) begin
            q.push_back(1'b0);
            for (int k = 0; k < 8; k++) q.push_back(m_mem[b][k]);
            q.push_back(1'b1);
        end
    endtask

    task automatic model_edge(input bit be, input bit w, input bit [6:0] a, input bit [7:0] d);
        bit fin = 0;
        if (!m_en) m_state = 0;
        else if (m_state == 1) begin
            if (m_seiz == 0 && m_mark == 0 && m_dlen == 0) m_state = 0;
            else begin
                build();
                if (q.size() == 0) fin = 1; else m_state = 2;
            end
        end else if (m_state == 2 && be) begin
            void'(q.pop_front());
            if (q.size() == 0) fin = 1;
        end
        if (fin) m_state = m_hold ? 3 : 0;
        if (w) begin
            case (a)
                7'h35: m_seiz = d;
                7'h36: m_dlen = d;
                7'h37: m_mark = d;
                7'h38: begin
                    m_hold = d[1]; m_uk = d[2]; m_chan = d[5:3]; m_en = d[7];
                    if (d[0] && d[7]) begin
                        if (m_state == 0) begin m_state = 1; m_from_hold = 0; end
                        else if (m_state == 3 && !d[1]) begin m_state = 1; m_from_hold = 1; end
                    end
                end
                default: ;
            endcase
        end
    endtask

    task automatic compare();
        bit ev, eb;
        ev = (m_state == 2) || (m_state == 3) || (m_state == 1 && m_from_hold);
        eb = (m_state == 2) ? q[0] : 1'b1;
        chk(tx_valid === ev, "tx_valid", int'(tx_valid), int'(ev));
        chk(tx_bit === eb, "tx_bit", int'(tx_bit), int'(eb));
        chk(tx_chan === m_chan, "tx_chan", int'(tx_chan), int'(m_chan));
        if (tx_valid) vcount++;
    endtask

    task automatic step(input bit be);
        bit w; bit [6:0] a; bit [7:0] d;
        bit_en = be;
        w = reg_req && !reg_cmd[7]; a = reg_cmd[6:0]; d = reg_wdata;
        @(posedge clk);
        model_edge(be, w, a, d);
        @(negedge clk);
        compare();
        reg_req = 0; buf_wr = 0; bit_en = 0;
    endtask

    task automatic wr(input bit [6:0] a, input bit [7:0] d);
        reg_req = 1; reg_cmd = {1'b0, a}; reg_wdata = d;
        step(0);
    endtask

    task automatic rd(input bit [6:0] a, input bit [7:0] exp, input string what);
        reg_req = 1; reg_cmd = {1'b1, a};
        step(0);
        chk(reg_rdata === exp, what, int'(reg_rdata), int'(exp));
    endtask

    task automatic run(input int n, input int period);
        for (int i = 0; i < n; i++) step((i % period) == period - 1);
    endtask

    task automatic run_until(input int target, input int period);
        int i = 0;
        while (m_state != target && i < 5000) begin
            step((i % period) == period - 1);
            i++;
        end
        chk(m_state == target, "burst did not reach end state", m_state, target);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        tag = "R2 reset";
        chk(tx_valid === 1'b0, "tx_valid after reset", int'(tx_valid), 0);
        chk(tx_bit === 1'b1, "tx_bit after reset", int'(tx_bit), 1);
        chk(tx_chan === 3'd0, "tx_chan after reset", int'(tx_chan), 0);
        for (int a = 'h35; a <= 'h38; a++) rd(7'(a), 8'h00, "R1 R2 register reset value");

        for (int i = 0; i < 64; i++) begin
            m_mem[i] = 8'((i * 37 + 11) & 255);
            buf_wr = 1; buf_addr = 6'(i); buf_wdata = m_mem[i];
            step(0);
        end

        tag = "R1 R3 R4 R5 R6 R11 full burst, sparse bit enable";
        wr(7'h35, 8'd6); wr(7'h36, 8'd3); wr(7'h37, 8'd5);
        rd(7'h37, 8'd5, "R1 mark length readback");
        wr(7'h38, 8'hA9);
        run(20, 3);
        rd(7'h38, 8'hA9, "R7 start reads 1 mid-burst");
        run_until(0, 3);
        tag = "R7 end of burst";
        rd(7'h38, 8'hA8, "R7 start cleared after last stop bit");
        chk(tx_valid === 1'b0 && tx_bit === 1'b1, "R7 muted after burst", int'({tx_valid, tx_bit}), 1);

        tag = "R4 UK mode skips seizure";
        wr(7'h35, 8'd6); wr(7'h36, 8'd2); wr(7'h37, 8'd0);
        vcount = 0;
        wr(7'h38, 8'h95);
        run_until(0, 1);
        chk(vcount == 20, "R4 valid bit count in UK mode", vcount, 20);

        tag = "R5 zero mark length";
        wr(7'h35, 8'd4); wr(7'h36, 8'd1); wr(7'h37, 8'd0);
        vcount = 0;
        wr(7'h38, 8'h81);
        run_until(0, 1);
        chk(vcount == 14, "R5 valid bit count with no mark", vcount, 14);

        tag = "R8 hold-after-send";
        wr(7'h35, 8'd0); wr(7'h36, 8'd1); wr(7'h37, 8'd3);
        wr(7'h38, 8'h83);
        run_until(3, 2);
        run(10, 2);
        wr(7'h38, 8'h83);
        run(6, 1);
        chk(tx_valid === 1'b1 && tx_bit === 1'b1, "R8 start with hold set keeps ones", int'({tx_valid, tx_bit}), 3);
        wr(7'h38, 8'h81);
        run_until(0, 2);
        chk(tx_valid === 1'b0, "R8 re-armed burst ends muted", int'(tx_valid), 0);

        tag = "R9 all lengths zero";
        wr(7'h35, 8'd0); wr(7'h36, 8'd0); wr(7'h37, 8'd0);
        vcount = 0;
        wr(7'h38, 8'h81);
        run(4, 1);
        rd(7'h38, 8'h80, "R9 start self-cleared");
        chk(vcount == 0, "R9 nothing sent", vcount, 0);

        tag = "R6 data length clamp at 64";
        wr(7'h36, 8'd100);
        vcount = 0;
        wr(7'h38, 8'h81);
        run_until(0, 1);
        chk(vcount == 640, "R6 valid bits for clamped length", vcount, 640);

        tag = "R10 disable mid-burst";
        wr(7'h35, 8'd10); wr(7'h36, 8'd2); wr(7'h37, 8'd10);
        wr(7'h38, 8'h81);
        run(15, 2);
        wr(7'h38, 8'h00);
        run(3, 1);
        chk(tx_valid === 1'b0, "R10 muted after disable", int'(tx_valid), 0);
        rd(7'h38, 8'h00, "R10 start cleared by disable");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule